// File: doc/BRIEF.md
# Seven-Segment Digit Decoder with Blanking Controls

This block turns a four-bit binary-coded-decimal digit into seven active-high segment drives. Besides plain decoding it has three active-low controls. A lamp-test input lights every segment. A forced-blank input turns the digit fully dark. A zero-blank input asks the digit to go dark when it holds zero.

A zero-blank output tells the next digit that this digit suppressed its zero. To suppress leading zeros on a multi-digit display, tie the most significant digit's zero-blank input low. Then feed each digit's zero-blank output into the zero-blank input of the next less significant digit. The ones digit normally has its zero-blank input tied high, so that a value of zero still shows one "0".

The block is purely combinational. Outputs follow the inputs with no clock and no state. When more than one control is active, a fixed priority decides the result.

Top module: `sevenseg_blank_decoder`

## Requirements
- R1: With `force_blank_n`, `lamp_test_n` and `zero_blank_in_n` all high, codes 0 to 9 light the standard segments. Segment a is `seg[0]` through segment g at `seg[6]`, so 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F and 9=0x6F.
- R2: With `force_blank_n` high and `lamp_test_n` low, `seg` is 0x7F whatever the code and `zero_blank_in_n` are.
- R3: With `force_blank_n` high, `lamp_test_n` high, `zero_blank_in_n` low and code 0, `seg` is 0x00 and `zero_blank_out_n` is low.
- R4: With `force_blank_n` low, `seg` is 0x00 whatever the other inputs are.
- R5: `zero_blank_out_n` is low only in the case of R3 and high in every other input combination.
- R6: The priority is forced blank first, then lamp test, then zero blanking, then normal decoding. A forced blank during lamp test gives 0x00, and lamp test during a zero-blank request gives 0x7F.
- R7: With `force_blank_n` and `lamp_test_n` high, codes 10 to 15 show only segment g (0x40) and leave `zero_blank_out_n` high, whatever `zero_blank_in_n` is.
- R8: `zero_blank_in_n` has no effect on `seg` for any nonzero code.
- R9: With the controls inactive and code 0, the digit shows 0x3F and `zero_blank_out_n` stays high, so a zero in the ones position remains visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| code | input | 4 | BCD digit to display |
| lamp_test_n | input | 1 | Active-low lamp test, lights all segments |
| zero_blank_in_n | input | 1 | Active-low request to blank a zero digit |
| force_blank_n | input | 1 | Active-low forced blank, darkens the digit |
| seg | output | 7 | Segment drives, bit 0 = a through bit 6 = g, active high |
| zero_blank_out_n | output | 1 | Active-low flag, low when this digit blanked its zero |

## Verification
The bench applies all 128 combinations of code and controls and compares each one against a table built from the requirements. The corner cases it targets are these. A forced blank combined with lamp test catches a priority inversion, which would light the digit. A zero-blank request on nonzero and invalid codes catches blanking that is not qualified by the code, which would darken real digits. Code 0 with lamp test, or with a forced blank, catches a ripple output that asserts too often, which would blank the next digit wrongly. A wrong segment constant or a wrong bit order shows up as a miscompare on the single code that uses it.

// File: rtl/sevenseg_pkg.sv
package sevenseg_pkg;

    localparam int CODE_W = 4;
    localparam int SEG_W  = 7;
    localparam int DIGITS = 10;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SEG_W-1:0]  seg_t;

    localparam seg_t SEG_DARK    = '0;
    localparam seg_t SEG_ALL     = '1;
    localparam seg_t SEG_INVALID = seg_t'(1) << (SEG_W - 1);

    typedef enum logic [1:0] {
        MODE_DARK  = 2'd0,
        MODE_LAMP  = 2'd1,
        MODE_ZBLNK = 2'd2,
        MODE_GLYPH = 2'd3
    } disp_mode_e;

    typedef struct packed {
        seg_t seg;
        logic zb_out_n;
    } dec_out_t;

endpackage

// File: rtl/seg_glyph_rom.sv
module seg_glyph_rom
    import sevenseg_pkg::*;
(
    input  code_t code,
    output seg_t  glyph
);

    seg_t digit_glyph [DIGITS];

    // Segment sets per digit, bit 0 = a ... bit 6 = g.
    assign digit_glyph[0] = 7'b011_1111;
    assign digit_glyph[1] = 7'b000_0110;
    assign digit_glyph[2] = 7'b101_1011;
    assign digit_glyph[3] = 7'b100_1111;
    assign digit_glyph[4] = 7'b110_0110;
    assign digit_glyph[5] = 7'b110_1101;
    assign digit_glyph[6] = 7'b111_1101;
    assign digit_glyph[7] = 7'b000_0111;
    assign digit_glyph[8] = 7'b111_1111;
    assign digit_glyph[9] = 7'b110_1111;

    seg_t glyph_d;

    always_comb begin
        glyph_d = SEG_INVALID;
        for (int i = 0; i < DIGITS; i++) begin
            if (code == code_t'(i)) glyph_d = digit_glyph[i];
        end
    end

    assign glyph = glyph_d;

endmodule

// File: rtl/seg_mode_arb.sv
module seg_mode_arb
    import sevenseg_pkg::*;
(
    input  code_t      code,
    input  logic       lamp_test_n,
    input  logic       zero_blank_in_n,
    input  logic       force_blank_n,
    output disp_mode_e mode
);

    disp_mode_e mode_d;
    logic       is_zero;

    assign is_zero = (code == '0);

    // Fixed priority: forced blank, lamp test, zero blank, glyph.
    always_comb begin
        if (!force_blank_n)                mode_d = MODE_DARK;
        else if (!lamp_test_n)             mode_d = MODE_LAMP;
        else if (!zero_blank_in_n && is_zero) mode_d = MODE_ZBLNK;
        else                               mode_d = MODE_GLYPH;
    end

    assign mode = mode_d;

endmodule

// File: rtl/seg_out_sel.sv
module seg_out_sel
    import sevenseg_pkg::*;
(
    input  disp_mode_e mode,
    input  seg_t       glyph,
    output dec_out_t   out
);

    dec_out_t out_d;

    always_comb begin
        out_d.zb_out_n = 1'b1;
        unique case (mode)
            MODE_DARK:  out_d.seg = SEG_DARK;
            MODE_LAMP:  out_d.seg = SEG_ALL;
            MODE_ZBLNK: begin
                out_d.seg      = SEG_DARK;
                out_d.zb_out_n = 1'b0;
            end
            default:    out_d.seg = glyph;
        endcase
    end

    assign out = out_d;

endmodule

// File: rtl/sevenseg_blank_decoder.sv
module sevenseg_blank_decoder
    import sevenseg_pkg::*;
(
    input  logic [3:0] code,
    input  logic       lamp_test_n,
    input  logic       zero_blank_in_n,
    input  logic       force_blank_n,
    output logic [6:0] seg,
    output logic       zero_blank_out_n
);

    seg_t       glyph;
    disp_mode_e mode;
    dec_out_t   out_d;

    seg_glyph_rom i_glyph (
        .code  (code),
        .glyph (glyph)
    );

    seg_mode_arb i_arb (
        .code            (code),
        .lamp_test_n     (lamp_test_n),
        .zero_blank_in_n (zero_blank_in_n),
        .force_blank_n   (force_blank_n),
        .mode            (mode)
    );

    seg_out_sel i_sel (
        .mode  (mode),
        .glyph (glyph),
        .out   (out_d)
    );

    assign seg              = out_d.seg;
    assign zero_blank_out_n = out_d.zb_out_n;

endmodule

// File: rtl/sevenseg_blank_checker.sv
module sevenseg_blank_checker (
    input logic [3:0] code,
    input logic       lamp_test_n,
    input logic       zero_blank_in_n,
    input logic       force_blank_n,
    input logic [6:0] seg,
    input logic       zero_blank_out_n
);

    logic zb_case;
    assign zb_case = force_blank_n && lamp_test_n && !zero_blank_in_n && (code == 4'd0);

    always_comb begin
        // R4, R6: forced blank wins over everything
        p_force_dark_r4: assert (force_blank_n || seg == 7'h00);
        // R2, R6: lamp test wins over zero blanking
        p_lamp_lit_r2: assert (!force_blank_n || lamp_test_n || seg == 7'h7F);
        // R3
        p_zero_blank_r3: assert (!zb_case || (seg == 7'h00 && !zero_blank_out_n));
        // R5
        p_ripple_only_r5: assert (zero_blank_out_n || zb_case);
        // R7
        p_invalid_code_r7: assert (!(force_blank_n && lamp_test_n && code > 4'd9)
                                   || (seg == 7'h40 && zero_blank_out_n));
    end

endmodule

bind sevenseg_blank_decoder sevenseg_blank_checker i_chk (
    .code             (code),
    .lamp_test_n      (lamp_test_n),
    .zero_blank_in_n  (zero_blank_in_n),
    .force_blank_n    (force_blank_n),
    .seg              (seg),
    .zero_blank_out_n (zero_blank_out_n)
);

// File: tb/test_sevenseg_blank_decoder.sv
module test_sevenseg_blank_decoder;

    logic       clk = 1'b0;
    logic [3:0] code = 4'd0;
    logic       lamp_test_n = 1'b1;
    logic       zero_blank_in_n = 1'b1;
    logic       force_blank_n = 1'b1;
    logic [6:0] seg;
    logic       zero_blank_out_n;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sevenseg_blank_decoder i_sevenseg_blank_decoder (
        .code             (code),
        .lamp_test_n      (lamp_test_n),
        .zero_blank_in_n  (zero_blank_in_n),
        .force_blank_n    (force_blank_n),
        .seg              (seg),
        .zero_blank_out_n (zero_blank_out_n)
    );

    function automatic logic [6:0] digit_ref(input logic [3:0] c);
        case (c)
            4'd0: return 7'h3F;
            4'd1: return 7'h06;
            4'd2: return 7'h5B;
            4'd3: return 7'h4F;
            4'd4: return 7'h66;
            4'd5: return 7'h6D;
            4'd6: return 7'h7D;
            4'd7: return 7'h07;
            4'd8: return 7'h7F;
            4'd9: return 7'h6F;
            default: return 7'h40;
        endcase
    endfunction

    task automatic apply_check(input logic [3:0] c, input logic lt, input logic zi,
                               input logic fb, input logic [6:0] exp_seg,
                               input logic exp_zo, input string req);
        @(negedge clk);
        code = c; lamp_test_n = lt; zero_blank_in_n = zi; force_blank_n = fb;
        #1;
        n_vec++;
        if (seg !== exp_seg || zero_blank_out_n !== exp_zo) begin
            n_bad++;
            $display("FAIL %s code=%0d lt=%b zi=%b fb=%b: seg=%h zo=%b expected seg=%h zo=%b",
                     req, c, lt, zi, fb, seg, zero_blank_out_n, exp_seg, exp_zo);
        end
    endtask

    // Idle state: controls inactive, code 0 shows a zero (R9)
    task automatic t_idle();
        apply_check(4'd0, 1'b1, 1'b1, 1'b1, 7'h3F, 1'b1, "R9");
    endtask

    task automatic t_decode();   // R1
        for (int c = 0; c < 10; c++)
            apply_check(4'(c), 1'b1, 1'b1, 1'b1, digit_ref(4'(c)), 1'b1, "R1");
    endtask

    task automatic t_lamp();     // R2, R6
        for (int c = 0; c < 16; c++)
            for (int z = 0; z < 2; z++)
                apply_check(4'(c), 1'b0, z[0], 1'b1, 7'h7F, 1'b1, "R2_R6");
    endtask

    task automatic t_zero_blank(); // R3, R8
        apply_check(4'd0, 1'b1, 1'b0, 1'b1, 7'h00, 1'b0, "R3");
        for (int c = 1; c < 10; c++)
            apply_check(4'(c), 1'b1, 1'b0, 1'b1, digit_ref(4'(c)), 1'b1, "R8");
    endtask

    task automatic t_force();    // R4, R5, R6
        for (int c = 0; c < 16; c++)
            for (int k = 0; k < 4; k++)
                apply_check(4'(c), k[0], k[1], 1'b0, 7'h00, 1'b1, "R4_R5_R6");
    endtask

    task automatic t_invalid();  // R7
        for (int c = 10; c < 16; c++)
            for (int z = 0; z < 2; z++)
                apply_check(4'(c), 1'b1, z[0], 1'b1, 7'h40, 1'b1, "R7");
    endtask

    task automatic t_chain();    // R3, R9 ripple into the next digit
        logic zo_upper;
        apply_check(4'd0, 1'b1, 1'b0, 1'b1, 7'h00, 1'b0, "R3");
        zo_upper = zero_blank_out_n;
        apply_check(4'd0, 1'b1, zo_upper, 1'b1, 7'h00, 1'b0, "R3");
        apply_check(4'd5, 1'b1, zo_upper, 1'b1, 7'h6D, 1'b1, "R5");
        apply_check(4'd0, 1'b1, 1'b1, 1'b1, 7'h3F, 1'b1, "R9");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_idle();
        t_decode();
        t_lamp();
        t_zero_blank();
        t_force();
        t_invalid();
        t_chain();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule